// File: doc/BRIEF.md
# Coprocessor Cycle-Counter Interlock Unit

This unit sits beside a host processor's decode stage and controls a multi-cycle reconfigurable array coprocessor. The host presents one coprocessor instruction per cycle with a 3-bit opcode, an interlock flag, a 16-bit immediate and a data word. The unit decodes the instruction and drives the matching strobe towards the array. The instruction kinds are: select configuration, push a word into the array, pull a word out of it, start a run, save context and restore context.

A start instruction loads a down-counter that measures how long the array runs. While the counter is nonzero, the unit stalls the host in two cases: the presented instruction carries the interlock flag, or it is another start. An instruction that is not stalled executes in the cycle it is presented. Save returns the counter and the sticky done flag to the host. Restore writes both back. Together they let an operating system swap an in-flight array context.

Top module: `cop_interlock`

## Requirements
- R1: Reset clears the counter (`cnt_o` = 0), the done flag and `rd_valid_o`. With the counter at zero, `stall_o` stays low whatever is issued.
- R2: An executed start (opcode 4) loads the counter with `imm_i`, and the new value shows on `cnt_o` after the next clock edge.
- R3: While nonzero, and unless a start or restore executes, the counter decrements by exactly one per clock. At zero it holds.
- R4: `done_o` becomes 1 on the same edge that takes the counter from 1 to 0. A start with a nonzero immediate clears it. A start with a zero immediate sets it.
- R5: A start issued while the counter is nonzero holds `stall_o` high until the counter reaches zero. It then executes, so a second start waits exactly the remaining count.
- R6: Any instruction issued with `ilk_i`=1 while the counter is nonzero holds `stall_o` high until the counter is zero. An instruction other than start with `ilk_i`=0 never stalls.
- R7: An executed pull-from-array (opcode 3) pulses `arr_rd_o` in its execute cycle. One cycle later, `rd_valid_o`=1 and `rd_data_o` equals the `arr_rdata_i` seen in the execute cycle.
- R8: An executed push-to-array (opcode 2) pulses `arr_wr_o` with `arr_wdata_o` = `wdata_i`. No array strobe is asserted while `stall_o` is high.
- R9: An executed configuration select (opcode 1) pulses `cfg_req_o` with `cfg_id_o` = `imm_i[CFG_W-1:0]`.
- R10: An executed save (opcode 5) returns, one cycle later, `rd_data_o[CW-1:0]` = the counter value and `rd_data_o[CW]` = done, both as they stood in the execute cycle. All higher bits are zero.
- R11: An executed restore (opcode 6) sets the counter from `wdata_i[CW-1:0]` and done from `wdata_i[CW]`. Counting resumes from the restored value.
- R12: Opcodes 0 and 7 assert no array strobe and no `rd_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Instruction presented this cycle |
| op_i | input | 3 | Opcode |
| ilk_i | input | 1 | Interlock flag: wait for counter zero |
| imm_i | input | CW | Immediate (run length, configuration id) |
| wdata_i | input | DW | Host data for push and restore |
| stall_o | output | 1 | Hold the host instruction |
| cnt_o | output | CW | Current counter value |
| done_o | output | 1 | Sticky run-complete flag |
| busy_o | output | 1 | Counter nonzero, array running |
| cfg_req_o | output | 1 | Configuration select strobe |
| cfg_id_o | output | CFG_W | Selected configuration |
| arr_wr_o | output | 1 | Push strobe to array |
| arr_wdata_o | output | DW | Pushed word |
| arr_rd_o | output | 1 | Pull strobe to array |
| arr_rdata_i | input | DW | Word from array |
| rd_valid_o | output | 1 | Result for host valid |
| rd_data_o | output | DW | Result for host |

## Verification
The hardest situation to reach is an instruction that arrives while the counter still holds a remaining run length. The stall must then last exactly that many cycles, and the instruction must execute on the very cycle the count expires. The bench first loads a run of each length from 0 to 12. It then presents an interlocked pull at once and counts the stall cycles, comparing the count against the length. It repeats the measurement for a second start issued behind a running one, and for a counter restored mid-run after a save.

// File: rtl/cop_il_pkg.sv
package cop_il_pkg;
   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_CFG  = 3'd1,
      OP_PUT  = 3'd2,
      OP_GET  = 3'd3,
      OP_RUN  = 3'd4,
      OP_SAVE = 3'd5,
      OP_LOAD = 3'd6,
      OP_RSV  = 3'd7
   } cop_op_e;
endpackage

// File: rtl/cop_il_decode.sv
module cop_il_decode
   import cop_il_pkg::*;
(
   input  logic       issue_i,
   input  logic [2:0] op_i,
   input  logic       ilk_i,
   input  logic       busy_i,
   output logic       stall_o,
   output logic       go_cfg_o,
   output logic       go_put_o,
   output logic       go_get_o,
   output logic       go_run_o,
   output logic       go_save_o,
   output logic       go_load_o
);
   cop_op_e op;
   logic    must_wait;
   logic    go;

   always_comb begin
      op        = cop_op_e'(op_i);
      must_wait = ilk_i || (op == OP_RUN);
      stall_o   = issue_i && busy_i && must_wait;
      go        = issue_i && !stall_o;
      go_cfg_o  = go && (op == OP_CFG);
      go_put_o  = go && (op == OP_PUT);
      go_get_o  = go && (op == OP_GET);
      go_run_o  = go && (op == OP_RUN);
      go_save_o = go && (op == OP_SAVE);
      go_load_o = go && (op == OP_LOAD);
   end
endmodule

// File: rtl/cop_il_counter.sv
module cop_il_counter #(
   parameter int CW = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          ld_run_i,
   input  logic [CW-1:0] run_len_i,
   input  logic          ld_ctx_i,
   input  logic [CW:0]   ctx_i,
   output logic [CW-1:0] cnt_o,
   output logic          done_o,
   output logic          busy_o
);
   logic [CW-1:0] cnt_q;
   logic          done_q;
   logic          at_one;

   assign busy_o = (cnt_q != '0);
   assign at_one = (cnt_q == CW'(1));
   assign cnt_o  = cnt_q;
   assign done_o = done_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (ld_run_i) begin
         cnt_q  <= run_len_i;
         done_q <= (run_len_i == '0);
      end else if (ld_ctx_i) begin
         cnt_q  <= ctx_i[CW-1:0];
         done_q <= ctx_i[CW];
      end else if (busy_o) begin
         cnt_q  <= cnt_q - CW'(1);
         if (at_one) done_q <= 1'b1;
      end
   end
endmodule

// File: rtl/cop_il_readback.sv
module cop_il_readback #(
   parameter int DW     = 32,
   parameter int CW     = 16,
   parameter bit RD_REG = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          get_i,
   input  logic          save_i,
   input  logic [DW-1:0] arr_rdata_i,
   input  logic [CW-1:0] cnt_i,
   input  logic          done_i,
   output logic          rd_valid_o,
   output logic [DW-1:0] rd_data_o
);
   logic [DW-1:0] snap;
   logic [DW-1:0] sel;
   logic          sel_v;

   always_comb begin
      snap         = '0;
      snap[CW-1:0] = cnt_i;
      snap[CW]     = done_i;
      sel          = get_i ? arr_rdata_i : snap;
      sel_v        = get_i || save_i;
   end

   if (RD_REG) begin : g_reg
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
         end else begin
            rd_valid_o <= sel_v;
            if (sel_v) rd_data_o <= sel;
         end
      end
   end else begin : g_comb
      assign rd_valid_o = sel_v;
      assign rd_data_o  = sel_v ? sel : '0;
   end
endmodule

// File: rtl/cop_interlock.sv
module cop_interlock #(
   parameter int DW     = 32,
   parameter int CW     = 16,
   parameter int CFG_W  = 4,
   parameter bit RD_REG = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             issue_i,
   input  logic [2:0]       op_i,
   input  logic             ilk_i,
   input  logic [CW-1:0]    imm_i,
   input  logic [DW-1:0]    wdata_i,
   output logic             stall_o,
   output logic [CW-1:0]    cnt_o,
   output logic             done_o,
   output logic             busy_o,
   output logic             cfg_req_o,
   output logic [CFG_W-1:0] cfg_id_o,
   output logic             arr_wr_o,
   output logic [DW-1:0]    arr_wdata_o,
   output logic             arr_rd_o,
   input  logic [DW-1:0]    arr_rdata_i,
   output logic             rd_valid_o,
   output logic [DW-1:0]    rd_data_o
);
   localparam int CTX_W = CW + 1;

   if (DW < CTX_W) begin : g_bad_dw
      $error("DW must hold the counter plus the done bit");
   end
   if (CFG_W > CW || CFG_W < 1) begin : g_bad_cfg
      $error("CFG_W must lie in 1..CW");
   end

   logic go_cfg, go_put, go_get, go_run, go_save, go_load;

   cop_il_decode u_dec (
      .issue_i   (issue_i),
      .op_i      (op_i),
      .ilk_i     (ilk_i),
      .busy_i    (busy_o),
      .stall_o   (stall_o),
      .go_cfg_o  (go_cfg),
      .go_put_o  (go_put),
      .go_get_o  (go_get),
      .go_run_o  (go_run),
      .go_save_o (go_save),
      .go_load_o (go_load)
   );

   cop_il_counter #(.CW(CW)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ld_run_i  (go_run),
      .run_len_i (imm_i),
      .ld_ctx_i  (go_load),
      .ctx_i     (wdata_i[CTX_W-1:0]),
      .cnt_o     (cnt_o),
      .done_o    (done_o),
      .busy_o    (busy_o)
   );

   cop_il_readback #(.DW(DW), .CW(CW), .RD_REG(RD_REG)) u_rb (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .get_i       (go_get),
      .save_i      (go_save),
      .arr_rdata_i (arr_rdata_i),
      .cnt_i       (cnt_o),
      .done_i      (done_o),
      .rd_valid_o  (rd_valid_o),
      .rd_data_o   (rd_data_o)
   );

   assign cfg_req_o   = go_cfg;
   assign cfg_id_o    = imm_i[CFG_W-1:0];
   assign arr_wr_o    = go_put;
   assign arr_wdata_o = wdata_i;
   assign arr_rd_o    = go_get;
endmodule

// File: rtl/cop_interlock_chk.sv
module cop_interlock_chk #(
   parameter int CW     = 16,
   parameter bit RD_REG = 1'b1
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          issue_i,
   input logic [2:0]    op_i,
   input logic          ilk_i,
   input logic [CW-1:0] imm_i,
   input logic          stall_o,
   input logic [CW-1:0] cnt_o,
   input logic          done_o,
   input logic          busy_o,
   input logic          cfg_req_o,
   input logic          arr_wr_o,
   input logic          arr_rd_o,
   input logic          rd_valid_o
);
   logic exec, reload;
   assign exec   = issue_i && !stall_o;
   assign reload = exec && (op_i == 3'd4 || op_i == 3'd6);

   // R1
   idle_counter_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_o == '0) |-> !stall_o);

   // R2
   run_loads_imm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exec && op_i == 3'd4) |=> (cnt_o == $past(imm_i)));

   // R3
   step_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !reload) |=> (cnt_o == CW'($past(cnt_o) - CW'(1))));

   // R4
   done_on_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_o == CW'(1) && !reload) |=> done_o);

   // R5
   run_waits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (issue_i && op_i == 3'd4 && busy_o) |-> stall_o);

   // R6
   ilk_waits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (issue_i && ilk_i && busy_o) |-> stall_o);

   // R6
   no_ilk_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (issue_i && !ilk_i && op_i != 3'd4) |-> !stall_o);

   // R8
   quiet_in_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_o |-> !(arr_wr_o || arr_rd_o || cfg_req_o));

   // R12
   nop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 3'd0 || op_i == 3'd7 || !issue_i) |-> !(arr_wr_o || arr_rd_o || cfg_req_o));

   if (RD_REG) begin : g_rd
      // R7
      pull_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         arr_rd_o |=> rd_valid_o);
   end
endmodule

bind cop_interlock cop_interlock_chk #(.CW(CW), .RD_REG(RD_REG)) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .issue_i    (issue_i),
   .op_i       (op_i),
   .ilk_i      (ilk_i),
   .imm_i      (imm_i),
   .stall_o    (stall_o),
   .cnt_o      (cnt_o),
   .done_o     (done_o),
   .busy_o     (busy_o),
   .cfg_req_o  (cfg_req_o),
   .arr_wr_o   (arr_wr_o),
   .arr_rd_o   (arr_rd_o),
   .rd_valid_o (rd_valid_o)
);

// File: tb/cop_interlock_tb.sv
`timescale 1ns/1ps
module cop_interlock_tb_top;
   localparam int DW = 32;
   localparam int CW = 16;
   localparam int CFG_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic issue = 1'b0;
   logic [2:0] op = 3'd0;
   logic ilk = 1'b0;
   logic [CW-1:0] imm = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata = '0;
   logic stall, done, busy, cfg_req, arr_wr, arr_rd, rd_valid;
   logic [CW-1:0] cnt;
   logic [CFG_W-1:0] cfg_id;
   logic [DW-1:0] arr_wdata, rd_data;

   int total = 0;
   int bad = 0;
   logic s_cfg, s_wr, s_rd;
   logic [CFG_W-1:0] s_id;
   logic [DW-1:0] s_wdata;

   always #4 clk = ~clk;

   cop_interlock #(.DW(DW), .CW(CW), .CFG_W(CFG_W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .op_i(op), .ilk_i(ilk),
      .imm_i(imm), .wdata_i(wdata), .stall_o(stall), .cnt_o(cnt), .done_o(done),
      .busy_o(busy), .cfg_req_o(cfg_req), .cfg_id_o(cfg_id), .arr_wr_o(arr_wr),
      .arr_wdata_o(arr_wdata), .arr_rd_o(arr_rd), .arr_rdata_i(rdata),
      .rd_valid_o(rd_valid), .rd_data_o(rd_data)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // present one instruction at a negedge, wait out the stall, return one edge after execute
   task automatic do_op(input logic [2:0] o, input logic f, input logic [CW-1:0] im,
                        input logic [DW-1:0] wd, output int st);
      st = 0;
      issue = 1'b1; op = o; ilk = f; imm = im; wdata = wd;
      #1;
      while (stall) begin
         if (arr_wr || arr_rd || cfg_req) chk("R8 strobe during stall", 1, 0);
         st++;
         @(negedge clk); #1;
      end
      s_cfg = cfg_req; s_wr = arr_wr; s_rd = arr_rd; s_id = cfg_id; s_wdata = arr_wdata;
      @(negedge clk);
      issue = 1'b0; op = 3'd0; ilk = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int st;
      // R1: reset state, interlocked start presented in reset
      issue = 1'b1; op = 3'd4; ilk = 1'b1; imm = 16'd9;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 cnt", cnt, 0);
      chk("R1 done", done, 0);
      chk("R1 stall", stall, 0);
      chk("R1 rd_valid", rd_valid, 0);
      @(negedge clk);
      issue = 1'b0; op = 3'd0; ilk = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R4 R6 R7: run length sweep, interlocked pull waits exactly N
      for (int n = 0; n <= 12; n++) begin
         do_op(3'd4, 1'b0, CW'(n), '0, st);
         chk("R2 loaded count", cnt, n);
         chk("R4 done after start", done, (n == 0));
         rdata = 32'hA500_0000 + n;
         do_op(3'd3, 1'b1, '0, '0, st);
         chk("R6 interlock stall length", st, n);
         chk("R7 pull strobe", s_rd, 1);
         chk("R7 result valid", rd_valid, 1);
         chk("R7 result data", rd_data, 32'hA500_0000 + n);
         chk("R4 done at zero", done, 1);
      end

      // R3: step down one per clock, hold at zero
      do_op(3'd4, 1'b0, 16'd5, '0, st);
      for (int k = 1; k <= 7; k++) begin
         @(negedge clk);
         chk("R3 decrement", cnt, (k >= 5) ? 0 : 5 - k);
      end

      // R5: second start behind a running one
      do_op(3'd4, 1'b0, 16'd4, '0, st);
      do_op(3'd4, 1'b0, 16'd6, '0, st);
      chk("R5 start stall length", st, 4);
      chk("R5 new count", cnt, 6);
      chk("R4 done cleared", done, 0);

      // R6 R8: push without interlock while busy executes at once
      do_op(3'd2, 1'b0, '0, 32'hDEAD_BEEF, st);
      chk("R6 no stall", st, 0);
      chk("R8 push strobe", s_wr, 1);
      chk("R8 push data", s_wdata, 32'hDEAD_BEEF);
      chk("R3 count during push", cnt, 5);

      // R6: pull without interlock while busy does not wait
      do_op(3'd3, 1'b0, '0, '0, st);
      chk("R6 pull no stall", st, 0);

      // R10 R11: save mid-run then restore
      repeat (4) @(negedge clk);
      chk("R3 before save", cnt, 0);
      do_op(3'd4, 1'b0, 16'd10, '0, st);
      repeat (3) @(negedge clk);
      do_op(3'd5, 1'b0, '0, '0, st);
      chk("R10 saved context", rd_data, 32'd7);
      chk("R10 count after save", cnt, 6);
      do_op(3'd6, 1'b0, '0, 32'h0000_0003, st);
      chk("R11 restored count", cnt, 3);
      chk("R11 restored done", done, 0);
      do_op(3'd1, 1'b1, 16'h0002, '0, st);
      chk("R11 resumed countdown", st, 3);
      chk("R4 done after restore run", done, 1);
      do_op(3'd6, 1'b0, '0, 32'h0001_0000, st);
      chk("R11 restore done bit", done, 1);
      do_op(3'd5, 1'b0, '0, '0, st);
      chk("R10 save done bit", rd_data, 32'h0001_0000);

      // R9: every configuration id
      for (int id = 0; id < 16; id++) begin
         do_op(3'd1, 1'b0, CW'(16'h0F0 + id), '0, st);
         chk("R9 cfg strobe", s_cfg, 1);
         chk("R9 cfg id", s_id, id);
      end

      // R12: opcodes 0 and 7 are quiet
      do_op(3'd0, 1'b0, '0, '0, st);
      chk("R12 nop quiet", {s_cfg, s_wr, s_rd, rd_valid}, 0);
      do_op(3'd7, 1'b0, '0, '0, st);
      chk("R12 op7 quiet", {s_cfg, s_wr, s_rd, rd_valid}, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule